// File: doc/BRIEF.md
# Power-State-Aware Watchdog Timer

This block counts ticks of a slow, free-running time base. When the count runs out it raises a time-out. What the time-out does depends on whether the processor is executing code. In the run state it emits a one-cycle watchdog reset pulse. In any idle or sleep state it emits a one-cycle wake pulse, so the power controller can return the device to a run state. A sticky status bit records that a time-out happened.

The count is a base counter followed by a postscaler. The postscaler ratio is a power of two selected by a parameter. Four events restart the count from zero:
- entering sleep;
- an explicit watchdog-clear instruction;
- loss of the selected system clock;
- a write to the internal oscillator frequency field, but only while the fail-safe clock monitor is enabled and the internal oscillator drives the device clock.

The block also reports whether the slow oscillator must keep running during sleep.

Top module: `mode_wdt`

## Requirements
- R1: With `pwr_state` equal to 2'b00 (run), a time-out drives `wdt_rst_o` high for exactly one cycle. This is the cycle after the clock edge that sampled the final tick. `wake_o` stays low.
- R2: With `pwr_state` at any non-zero code (2'b01 idle, 2'b10 sleep, 2'b11 treated as idle), a time-out drives `wake_o` high for exactly one cycle instead. `wdt_rst_o` stays low.
- R3: A time-out occurs on exactly the 2^(CNT_W+PS_LOG2)-th enabled tick after reset or after the last clear, and not before. PS_LOG2 ranges from 0 to 15, giving a postscaler ratio of 1 to 32768. Counting restarts from zero after each time-out.
- R4: A `sleep_exec` strobe clears both the base counter and the postscaler.
- R5: A `clrwdt_exec` strobe clears both counters and also clears `to_flag`.
- R6: A `clk_lost` strobe clears both counters.
- R7: A `freq_wr` strobe clears both counters only when `fscm_en` and `intosc_sel` are both high. In the other three combinations it has no effect on the count.
- R8: While `wdt_en` is low, both counters are held at zero and no time-out occurs. After re-enabling, a full period is needed.
- R9: `to_flag` is set by any time-out and stays set until `clrwdt_exec` or reset.
- R10: `lf_keep_on` is high whenever `wdt_en` or `fscm_en` is high.
- R11: A clear event in the same cycle as a tick wins: that tick is not counted and no time-out occurs.
- R12: Synchronous reset drives `wdt_rst_o`, `wake_o` and `to_flag` low and zeroes both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle tick from the slow oscillator |
| wdt_en | input | 1 | Watchdog enable |
| pwr_state | input | 2 | 00 run, 01 idle, 10 sleep, 11 idle |
| sleep_exec | input | 1 | Sleep instruction executed (strobe) |
| clrwdt_exec | input | 1 | Watchdog-clear instruction executed (strobe) |
| clk_lost | input | 1 | Selected clock source lost (strobe) |
| freq_wr | input | 1 | Write to internal frequency field (strobe) |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| intosc_sel | input | 1 | Internal oscillator is the device clock |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |
| wake_o | output | 1 | One-cycle wake request pulse |
| to_flag | output | 1 | Sticky time-out status |
| lf_keep_on | output | 1 | Slow oscillator must stay running |

## Verification
The assertions assume that `pwr_state` is stable during the cycle of the final tick. They also assume that `lf_tick` is a single-cycle strobe already synchronous to `clk`. The bench changes `pwr_state` only after a time-out has completed, and it raises each tick for one cycle at the falling edge. Clear strobes are likewise held for one cycle. In one deliberate case a strobe coincides with a tick, to exercise R11.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_IDLE  = 2'b01,
        PWR_SLEEP = 2'b10,
        PWR_RSVD  = 2'b11
    } pwr_e;

    typedef struct packed {
        logic on_sleep;
        logic on_clrwdt;
        logic on_lost;
        logic on_freq;
    } clr_req_t;

    typedef struct packed {
        logic fire;
        logic executing;
    } to_evt_t;

    function automatic logic is_executing(input pwr_e p);
        return p == PWR_RUN;
    endfunction

    function automatic logic freq_clear_ok(input logic wr, input logic fscm,
                                           input logic intosc);
        return wr & fscm & intosc;
    endfunction

    function automatic logic any_clear(input clr_req_t r);
        return r.on_sleep | r.on_clrwdt | r.on_lost | r.on_freq;
    endfunction

endpackage

// File: rtl/mwdt_clear.sv
module mwdt_clear
    import mwdt_pkg::*;
(
    input  logic sleep_exec,
    input  logic clrwdt_exec,
    input  logic clk_lost,
    input  logic freq_wr,
    input  logic fscm_en,
    input  logic intosc_sel,
    output logic cnt_clr,
    output logic flag_clr
);

    clr_req_t req;

    always_comb begin
        req.on_sleep  = sleep_exec;
        req.on_clrwdt = clrwdt_exec;
        req.on_lost   = clk_lost;
        req.on_freq   = freq_clear_ok(freq_wr, fscm_en, intosc_sel);
        cnt_clr       = any_clear(req);
        flag_clr      = req.on_clrwdt;
    end

endmodule

// File: rtl/mwdt_count.sv
module mwdt_count #(
    parameter int CNT_W   = 7,
    parameter int PS_LOG2 = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic rollover
);

    logic [CNT_W-1:0] cnt_q;
    logic             base_full;
    logic             ps_full;
    logic             step;

    assign base_full = &cnt_q;
    assign step      = en & tick & ~clr;
    assign rollover  = step & base_full & ps_full;

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (PS_LOG2 > 0) begin : g_post
            logic [PS_LOG2-1:0] ps_q;
            assign ps_full = &ps_q;
            always_ff @(posedge clk) begin
                if (rst || clr || !en) begin
                    ps_q <= '0;
                end else if (step && base_full) begin
                    ps_q <= ps_q + 1'b1;
                end
            end
        end else begin : g_nopost
            assign ps_full = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/mwdt_action.sv
module mwdt_action
    import mwdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  to_evt_t evt,
    input  logic    flag_clr,
    output logic    wdt_rst_o,
    output logic    wake_o,
    output logic    to_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_rst_o <= 1'b0;
            wake_o    <= 1'b0;
            to_flag   <= 1'b0;
        end else begin
            wdt_rst_o <= evt.fire & evt.executing;
            wake_o    <= evt.fire & ~evt.executing;
            if (evt.fire) begin
                to_flag <= 1'b1;
            end else if (flag_clr) begin
                to_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mode_wdt.sv
module mode_wdt
    import mwdt_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int PS_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lf_tick,
    input  logic       wdt_en,
    input  logic [1:0] pwr_state,
    input  logic       sleep_exec,
    input  logic       clrwdt_exec,
    input  logic       clk_lost,
    input  logic       freq_wr,
    input  logic       fscm_en,
    input  logic       intosc_sel,
    output logic       wdt_rst_o,
    output logic       wake_o,
    output logic       to_flag,
    output logic       lf_keep_on
);

    localparam int TOTAL_W = CNT_W + PS_LOG2;

    logic    cnt_clr;
    logic    flag_clr;
    logic    rollover;
    to_evt_t evt;

    initial begin
        if (CNT_W < 1 || PS_LOG2 < 0 || PS_LOG2 > 15 || TOTAL_W > 31) begin
            $error("mode_wdt: unsupported counter configuration");
        end
    end

    mwdt_clear u_clear (
        .sleep_exec  (sleep_exec),
        .clrwdt_exec (clrwdt_exec),
        .clk_lost    (clk_lost),
        .freq_wr     (freq_wr),
        .fscm_en     (fscm_en),
        .intosc_sel  (intosc_sel),
        .cnt_clr     (cnt_clr),
        .flag_clr    (flag_clr)
    );

    mwdt_count #(
        .CNT_W   (CNT_W),
        .PS_LOG2 (PS_LOG2)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .en       (wdt_en),
        .tick     (lf_tick),
        .clr      (cnt_clr),
        .rollover (rollover)
    );

    always_comb begin
        evt.fire      = rollover;
        evt.executing = is_executing(pwr_e'(pwr_state));
    end

    mwdt_action u_action (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .flag_clr  (flag_clr),
        .wdt_rst_o (wdt_rst_o),
        .wake_o    (wake_o),
        .to_flag   (to_flag)
    );

    assign lf_keep_on = wdt_en | fscm_en;

endmodule

// File: rtl/mwdt_checker.sv
module mwdt_checker (
    input logic       clk,
    input logic       rst,
    input logic       wdt_en,
    input logic [1:0] pwr_state,
    input logic       sleep_exec,
    input logic       clrwdt_exec,
    input logic       clk_lost,
    input logic       freq_wr,
    input logic       fscm_en,
    input logic       intosc_sel,
    input logic       wdt_rst_o,
    input logic       wake_o,
    input logic       to_flag
);

    AST_RST_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> $past(pwr_state) == 2'b00); // R1

    AST_WAKE_ONLY_IN_LOW_POWER: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(pwr_state) != 2'b00); // R2

    AST_RST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> !wdt_rst_o); // R1

    AST_WAKE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o); // R2

    AST_NO_BOTH_ACTIONS: assert property (@(posedge clk) disable iff (rst)
        !(wdt_rst_o && wake_o)); // R2

    AST_CLEAR_BLOCKS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_exec || clrwdt_exec || clk_lost || (freq_wr && fscm_en && intosc_sel))
        |-> !(wdt_rst_o || wake_o)); // R11

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(!wdt_en) |-> !(wdt_rst_o || wake_o)); // R8

    AST_FLAG_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst_o || wake_o) |-> to_flag); // R9

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(clrwdt_exec) |-> !to_flag); // R5

endmodule

bind mode_wdt mwdt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wdt_en      (wdt_en),
    .pwr_state   (pwr_state),
    .sleep_exec  (sleep_exec),
    .clrwdt_exec (clrwdt_exec),
    .clk_lost    (clk_lost),
    .freq_wr     (freq_wr),
    .fscm_en     (fscm_en),
    .intosc_sel  (intosc_sel),
    .wdt_rst_o   (wdt_rst_o),
    .wake_o      (wake_o),
    .to_flag     (to_flag)
);

// File: tb/mode_wdt_bench.sv
module mode_wdt_bench;

    localparam int CNT_W   = 2;
    localparam int PS_LOG2 = 2;
    localparam int NPER    = 1 << (CNT_W + PS_LOG2);
    localparam int LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lf_tick = 1'b0;
    logic       wdt_en = 1'b1;
    logic [1:0] pwr_state = 2'b00;
    logic       sleep_exec = 1'b0;
    logic       clrwdt_exec = 1'b0;
    logic       clk_lost = 1'b0;
    logic       freq_wr = 1'b0;
    logic       fscm_en = 1'b0;
    logic       intosc_sel = 1'b0;
    logic       wdt_rst_o;
    logic       wake_o;
    logic       to_flag;
    logic       lf_keep_on;

    int checks = 0;
    int errors = 0;
    int rs_seen = 0;
    int wk_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mode_wdt #(.CNT_W(CNT_W), .PS_LOG2(PS_LOG2)) u_mode_wdt (
        .clk(clk), .rst(rst), .lf_tick(lf_tick), .wdt_en(wdt_en),
        .pwr_state(pwr_state), .sleep_exec(sleep_exec),
        .clrwdt_exec(clrwdt_exec), .clk_lost(clk_lost), .freq_wr(freq_wr),
        .fscm_en(fscm_en), .intosc_sel(intosc_sel), .wdt_rst_o(wdt_rst_o),
        .wake_o(wake_o), .to_flag(to_flag), .lf_keep_on(lf_keep_on)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sample();
        if (wdt_rst_o) rs_seen++;
        if (wake_o) wk_seen++;
    endtask

    task automatic clear_seen();
        rs_seen = 0;
        wk_seen = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            lf_tick = 1'b1;
            @(negedge clk);
            lf_tick = 1'b0;
            sample();
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                sample();
            end
        end
    endtask

    // src: 0 sleep, 1 clrwdt, 2 clock lost, 3 frequency write
    task automatic strobe(input int src, input bit with_tick);
        case (src)
            0: sleep_exec = 1'b1;
            1: clrwdt_exec = 1'b1;
            2: clk_lost = 1'b1;
            default: freq_wr = 1'b1;
        endcase
        lf_tick = with_tick;
        @(negedge clk);
        sleep_exec = 1'b0; clrwdt_exec = 1'b0; clk_lost = 1'b0; freq_wr = 1'b0;
        lf_tick = 1'b0;
        sample();
    endtask

    task automatic restart();
        strobe(1, 1'b0);
        clear_seen();
    endtask

    initial begin
        #(LIMIT * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(wdt_rst_o == 0 && wake_o == 0 && to_flag == 0, "R12 outputs in reset",
            {wdt_rst_o, wake_o, to_flag}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3: every power code, two tick spacings
        for (int gap = 0; gap < 3; gap += 2) begin
            for (int m = 0; m < 4; m++) begin
                pwr_state = m[1:0];
                clear_seen();
                ticks(NPER - 1, gap);
                chk(rs_seen == 0 && wk_seen == 0, "R3 no early time-out", rs_seen + wk_seen, 0);
                lf_tick = 1'b1;
                @(negedge clk);
                lf_tick = 1'b0;
                chk(wdt_rst_o == (m == 0), "R1 reset pulse by state", wdt_rst_o, m == 0);
                chk(wake_o == (m != 0), "R2 wake pulse by state", wake_o, m != 0);
                chk(to_flag == 1, "R9 flag set", to_flag, 1);
                @(negedge clk);
                chk(wdt_rst_o == 0 && wake_o == 0, "R1 R2 single-cycle pulse",
                    wdt_rst_o + wake_o, 0);
            end
        end

        // R9 sticky then R5 clear of flag
        pwr_state = 2'b01;
        ticks(5, 1);
        chk(to_flag == 1, "R9 flag sticky", to_flag, 1);
        restart();
        chk(to_flag == 0, "R5 clrwdt clears flag", to_flag, 1'b0);

        // R4 R5 R6 R7: sweep every clear source at every count offset
        fscm_en = 1'b1;
        intosc_sel = 1'b1;
        for (int src = 0; src < 4; src++) begin
            for (int k = 1; k < NPER; k++) begin
                restart();
                ticks(k, 0);
                strobe(src, 1'b0);
                ticks(NPER - 1, 0);
                chk(wk_seen == 0, src == 0 ? "R4 sleep clears count" :
                    src == 1 ? "R5 clrwdt clears count" :
                    src == 2 ? "R6 clock loss clears count" : "R7 freq write clears count",
                    wk_seen, 0);
                ticks(1, 0);
                chk(wk_seen == 1, "R3 full period after clear", wk_seen, 1);
            end
        end

        // R7 gating: freq write ignored unless both conditions hold
        for (int c = 0; c < 3; c++) begin
            fscm_en = c[0];
            intosc_sel = c[1];
            restart();
            ticks(NPER - 1, 0);
            strobe(3, 1'b0);
            ticks(1, 0);
            chk(wk_seen == 1, "R7 freq write ignored", wk_seen, 1);
        end
        fscm_en = 1'b0;
        intosc_sel = 1'b0;

        // R11 clear wins over a coincident tick
        restart();
        ticks(NPER - 1, 0);
        strobe(2, 1'b1);
        chk(wk_seen == 0, "R11 clear beats tick", wk_seen, 0);
        ticks(NPER - 1, 0);
        chk(wk_seen == 0, "R11 coincident tick not counted", wk_seen, 0);
        ticks(1, 0);
        chk(wk_seen == 1, "R11 period after coincident clear", wk_seen, 1);

        // R8 disable holds count at zero
        restart();
        ticks(NPER - 3, 0);
        wdt_en = 1'b0;
        ticks(2 * NPER, 0);
        chk(wk_seen == 0, "R8 disabled no time-out", wk_seen, 0);
        wdt_en = 1'b1;
        ticks(NPER - 1, 0);
        chk(wk_seen == 0, "R8 count restarted at zero", wk_seen, 0);
        ticks(1, 0);
        chk(wk_seen == 1, "R8 full period after enable", wk_seen, 1);

        // R10 oscillator keep-on, all four combinations
        for (int c = 0; c < 4; c++) begin
            wdt_en = c[0];
            fscm_en = c[1];
            #1;
            chk(lf_keep_on == (c != 0), "R10 keep-on", lf_keep_on, c != 0);
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule